// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the control port of a small configuration register bank, for example the bank of output enables in a clock generator. It is a slave only. A system clock at least sixteen times the bus bit rate samples the serial clock and data lines. The block finds start and stop conditions on those samples and answers one fixed 7-bit device address. It pulls the data line low through an open-drain enable when it needs to drive it. The register bank is always visible on a parallel output.

The port has no register pointer. A write to address byte 0xD2 is followed by a command byte and then a length byte. The block acknowledges both and then discards them. The data bytes after them fill register 0, register 1 and so on. A read from address byte 0xD3 returns a length byte first and then the registers in order. A power-down input releases the bus and keeps the bank as it is.

Top module: `cfg_i2c_slave`

## Requirements
- R1: A transaction begins only at a start condition, which is SDA falling while SCL is high. A stop condition, which is SDA rising while SCL is high, ends the transaction. Bytes clocked with no start condition before them get no acknowledge and change no register.
- R2: The address byte 0xD2 (device 7'h69, R/W=0) is acknowledged and opens a write. The address byte 0xD3 is acknowledged and opens a read. Any other address byte gets no acknowledge, and neither does anything after it up to the next start. Registers stay unchanged.
- R3: In a write, the 1st and 2nd bytes after the address are acknowledged and discarded. The bytes from the 3rd on go to register 0, register 1 and so on. Register i appears on regs_out[8i+7:8i].
- R4: Each byte is 8 bits, MSB first, sampled on the rising edge of SCL. The slave acknowledges each accepted byte by driving SDA low (sda_oe=1) during the 9th SCL pulse.
- R5: A write accepts at most 10 bytes after the address: the command byte, the length byte and 8 data bytes. From the 11th byte on there is no acknowledge and no register changes.
- R6: A read returns the length byte 8 first and then registers 0 to 7, each MSB first. While the master acknowledges, any byte after register 7 reads as 0xFF because SDA is released.
- R7: In a read, a byte the master does not acknowledge makes the slave release SDA. All later bytes read as 0xFF until the next start condition.
- R8: A repeated start at any point of a transaction restarts address decoding. Data already written stays in the registers.
- R9: While pwr_down is 1, sda_oe is 0, the register contents are held, and the bus is ignored.
- R10: After reset, every register holds 0xFF and sda_oe is 0.
- R11: Outside power-down, sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| pwr_down | input | 1 | 1 = release the bus and hold the registers |
| sda_oe | output | 1 | 1 = pull SDA low |
| regs_out | output | 64 | Register bank, register i in bits [8i+7:8i] |

## Verification
Random writes carry 0 to 11 data bytes. They show whether the discarded leading bytes, the sequential fill from register 0 and the cut-off after the 8th data byte are all placed correctly. Random reads of varying length end in a master NACK, which separates the length byte from register data and the slave's release from an early stop. Addresses that differ from 0xD2 or 0xD3, bytes clocked without a start and whole writes under power-down each have to leave the bank bit-for-bit unchanged. Directed cases cover a repeated start after a partial write, reading past register 7, and reading on after a NACK.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 8,
  parameter logic [7:0] REG_RESET = 8'hFF,
  localparam int        IW        = $clog2(NUM_REGS + 3),
  localparam int        AW        = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  pwr_down,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] regs_out
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    rx, tx, txb;
  logic [IW-1:0] idx;
  logic          ackd, txen, mack;
  logic [7:0]    regs [NUM_REGS];

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire active   = (st == S_ADDR) || (st == S_WR) || (st == S_RD);

  assign sda_oe = (ackd | (txen & ~tx[7])) & ~pwr_down;

  always_comb begin
    if (idx == '0)                  txb = 8'(NUM_REGS);
    else if (idx <= IW'(NUM_REGS))  txb = regs[AW'(idx - IW'(1))];
    else                            txb = 8'hFF;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_out[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      rx   <= '0;
      tx   <= 8'hFF;
      idx  <= '0;
      ackd <= 1'b0;
      txen <= 1'b0;
      mack <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= REG_RESET;
    end else if (pwr_down || stop_c) begin
      st   <= S_IDLE;
      cnt  <= '0;
      ackd <= 1'b0;
      txen <= 1'b0;
    end else if (start_c) begin
      st   <= S_ADDR;
      cnt  <= '0;
      ackd <= 1'b0;
      txen <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
        if (cnt < 4'd8) rx <= {rx[6:0], sda_s};
        if (cnt == 4'd8) mack <= ~sda_s;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          txen <= 1'b0;
          case (st)
            S_ADDR: begin
              idx <= '0;
              if (rx[7:1] == DEV_ADDR) begin
                ackd <= 1'b1;
                st   <= rx[0] ? S_RD : S_WR;
              end else begin
                st <= S_SKIP;
              end
            end
            S_WR: begin
              if (idx < IW'(NUM_REGS + 2)) begin
                ackd <= 1'b1;
                idx  <= idx + IW'(1);
                if (idx >= IW'(2)) regs[AW'(idx - IW'(2))] <= rx;
              end else begin
                st <= S_SKIP;
              end
            end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt  <= '0;
          ackd <= 1'b0;
          if (st == S_RD) begin
            if (mack) begin
              tx   <= txb;
              txen <= 1'b1;
              if (idx <= IW'(NUM_REGS)) idx <= idx + IW'(1);
            end else begin
              st <= S_SKIP;
            end
          end
        end else if (st == S_RD && cnt != 4'd0) begin
          tx <= {tx[6:0], 1'b1};
        end
      end
    end
  end

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_in,
  input logic         pwr_down,
  input logic         sda_oe,
  input logic [W-1:0] regs_out
);

  always_comb begin
    if (!rst_n) begin
      a_reset_release_r10: assert (!sda_oe);
    end
  end

  p_pd_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !sda_oe);

  p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> $stable(regs_out));

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !$past(pwr_down) && !$stable(sda_oe)) |-> !scl_in);

  p_write_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_out) |-> !scl_in);

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.W(8*NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .pwr_down(pwr_down),
  .sda_oe(sda_oe), .regs_out(regs_out)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic pd = 1'b0;
  logic sda_oe;
  logic [63:0] regs_out;
  wire sda_line = ~(m_low | sda_oe);

  int checks = 0;
  int fails = 0;
  logic [7:0] mreg [8];

  always #10 clk = ~clk;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .pwr_down(pd), .sda_oe(sda_oe), .regs_out(regs_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_bank();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = mreg[i];
    return v;
  endfunction

  function automatic bit exp_wr_ack(input int k);
    return k < 10;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    m_low = give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); m_low = 1'b0;
  endtask

  task automatic do_write(input int ndata);
    bit ack;
    logic [7:0] b;
    bus_start();
    put_byte(8'hD2, ack);
    chk(ack, "R2 write address ack", 64'(ack), 64'd1);
    for (int k = 0; k < ndata + 2; k++) begin
      b = 8'($urandom);
      put_byte(b, ack);
      chk(ack == exp_wr_ack(k), (k < 10) ? "R4 byte ack" : "R5 over-limit no ack", 64'(ack), 64'(exp_wr_ack(k)));
      if (k >= 2 && k < 10) mreg[k-2] = b;
    end
    bus_stop();
    chk(regs_out == model_bank(), "R3 register fill", regs_out, model_bank());
  endtask

  task automatic do_read(input int nbytes, input bit ack_last);
    bit ack;
    logic [7:0] b, e;
    bus_start();
    put_byte(8'hD3, ack);
    chk(ack, "R2 read address ack", 64'(ack), 64'd1);
    for (int k = 0; k < nbytes; k++) begin
      get_byte((k < nbytes - 1) || ack_last, b);
      e = (k == 0) ? 8'd8 : (k <= 8) ? mreg[k-1] : 8'hFF;
      chk(b == e, "R6 read data", 64'(b), 64'(e));
    end
    if (ack_last) begin
      get_byte(1'b0, b);
      chk(b == ((nbytes <= 8) ? mreg[nbytes-1] : 8'hFF), "R6 read continued", 64'(b),
          64'((nbytes <= 8) ? mreg[nbytes-1] : 8'hFF));
    end
    bus_stop();
  endtask

  task automatic do_bad_addr();
    bit ack;
    logic [7:0] a;
    a = 8'($urandom);
    if (a[7:1] == 7'h69) a = a ^ 8'h80;
    bus_start();
    put_byte(a, ack);
    chk(!ack, "R2 foreign address no ack", 64'(ack), 64'd0);
    for (int k = 0; k < 4; k++) begin
      put_byte(8'($urandom), ack);
      chk(!ack, "R2 bytes after foreign address", 64'(ack), 64'd0);
    end
    bus_stop();
    chk(regs_out == model_bank(), "R2 registers unchanged", regs_out, model_bank());
  endtask

  task automatic do_pd_write();
    bit ack;
    @(negedge clk); pd = 1'b1;
    bus_start();
    put_byte(8'hD2, ack);
    chk(!ack, "R9 no ack in power-down", 64'(ack), 64'd0);
    for (int k = 0; k < 5; k++) put_byte(8'($urandom), ack);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 bus released", 64'(sda_oe), 64'd0);
    chk(regs_out == model_bank(), "R9 registers held", regs_out, model_bank());
    @(negedge clk); pd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) mreg[i] = 8'hFF;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 reset oe", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(regs_out == {8{8'hFF}}, "R10 reset registers", regs_out, {8{8'hFF}});

    // R1: bytes with no start condition
    put_byte(8'hD2, ack);
    chk(!ack, "R1 no start no ack", 64'(ack), 64'd0);
    for (int k = 0; k < 3; k++) put_byte(8'h00, ack);
    chk(regs_out == model_bank(), "R1 no start no write", regs_out, model_bank());
    bus_stop();

    do_write(8);
    do_read(9, 1'b1);
    do_write(11);

    // R8: repeated start after a partial write
    bus_start();
    put_byte(8'hD2, ack); put_byte(8'h11, ack); put_byte(8'h22, ack);
    put_byte(8'h5A, ack); mreg[0] = 8'h5A;
    bus_start();
    put_byte(8'hD3, ack);
    chk(ack, "R8 repeated start read ack", 64'(ack), 64'd1);
    get_byte(1'b1, b);
    chk(b == 8'd8, "R8 count after repeated start", 64'(b), 64'd8);
    get_byte(1'b0, b);
    chk(b == 8'h5A, "R8 register kept", 64'(b), 64'h5A);
    // R7: after NACK the slave stays released
    get_byte(1'b0, b);
    chk(b == 8'hFF, "R7 released after nack", 64'(b), 64'hFF);
    bus_start();
    put_byte(8'hD2, ack); put_byte(8'h00, ack); put_byte(8'h00, ack);
    put_byte(8'hC3, ack); mreg[0] = 8'hC3;
    bus_stop();
    chk(regs_out[7:0] == 8'hC3, "R8 write after repeated start", 64'(regs_out[7:0]), 64'hC3);

    for (int t = 0; t < 22; t++) begin
      case ($urandom_range(0, 3))
        0: do_write($urandom_range(0, 11));
        1: do_read($urandom_range(1, 9), 1'b0);
        2: do_bad_addr();
        default: do_pd_write();
      endcase
    end
    do_read(9, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule